// File: doc/BRIEF.md
# Panel Bus Command and Pixel Controller

This block drives up to two external display panels that hold their own frame memory. Each panel has its own chip select and all of them share a 16-bit write/read strobe bus with a command/data select line. A processor reaches the block through a 32-bit register port. Through that port it stores control and configuration values, sends commands, parameters and pixel words to the panels, and starts panel read cycles whose results land in a receive register.

A transfer is opened with a start trigger in the control register. While it is open, a pixel counter counts down once for each data write, data read or status read. When the counter reaches zero the busy flag drops and a single-cycle frame-done pulse goes to the interrupt logic. The register port lowers its ready output for as long as a panel strobe sequence is running. A 32-bit data write becomes two 16-bit panel writes: the low halfword goes first, then the high halfword.

Top module: `pfb_ctrl`

## Requirements
- R1: After reset the control register reads 2, both configuration registers read 0x00310000, the pixel counter reads 0, status reads 0x1, ready is high, both chip selects and both strobes are high (inactive), and chip selects and strobes stay inactive whenever ready is high.
- R2: Word addresses are 0 sysconfig, 1 status, 2 control, 3 pixel count, 4 command, 5 parameter, 6 data, 7 data read, 8 status read, 9 config A and 10 config B. Control keeps only bits 3:0, the configuration registers keep the written value masked with 0x003F1FFF, and sysconfig keeps the written value masked with 0x19.
- R3: A control write with bit 4 set starts a transfer, and sets bit 8 of the status register, only when bit 0 of the written value is 1, bit 1 of the written value is 0, the block is not busy, and the display-mode input is high. Otherwise busy stays 0.
- R4: A start is refused when the two configuration registers share a set bit within bits 3:2.
- R5: A command write produces one write strobe that carries the low 16 bits of the value with the select line low (command level). Every panel enabled in control bit 2 (panel 0, chip select bit 0) and bit 3 (panel 1, chip select bit 1) is selected at the same time.
- R6: A parameter write behaves like a command write but with the select line high (data level).
- R7: A data write produces two write strobes at data level: bits 15:0 first, then bits 31:16.
- R8: A data write, data-read write or status-read write decrements the pixel counter by one. If the block is busy and the counter goes from 1 to 0, busy clears and frame_done is high for exactly one cycle. Command and parameter writes leave the counter unchanged.
- R9: A data-read or status-read write strobes the read line on panel 0 if it is selected, otherwise on panel 1. The select line is high for a data read and low for a status read. The sampled 16-bit value can then be read at address 7 or 8.
- R10: Each panel cycle holds the strobe low for STB_CYC cycles followed by one recovery cycle, and ready stays low for the whole sequence. A panel access with no panel selected produces no strobe and leaves ready high.
- R11: A sysconfig write with bit 1 set returns control, pixel count, both configuration registers and busy to their reset values without a frame-done pulse, and stores the written idle field.
- R12: The write and read strobes are never low in the same cycle, and each read strobe selects exactly one panel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, taken on a clock edge where host_ready is high |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 4 | Register word address |
| host_wdata | input | 32 | Write value |
| host_rdata | output | 32 | Read value for host_addr (combinational) |
| host_ready | output | 1 | High when no panel cycle is running |
| disp_mode | input | 1 | Display path is set to panel-bus mode |
| pnl_cs_n | output | 2 | Active-low chip selects, bit i for panel i |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| pnl_dc | output | 1 | 0 command level, 1 data level |
| pnl_dout | output | 16 | Panel write data |
| pnl_oe | output | 1 | Drive enable for pnl_dout |
| pnl_din | input | 16 | Panel read data |
| frame_done | output | 1 | One-cycle pulse at transfer end |

## Verification
Register writes take effect on the accepting edge, so read-back and status checks come after the next falling edge. The first strobe goes low one cycle after acceptance and the write strobe rises STB_CYC cycles later. The panel model therefore logs each strobe at its rising edge, while data, select and chip selects are still held in the recovery cycle, and it counts how many falling edges saw the strobe low. Ready is counted low for 2*(STB_CYC+1) falling edges after a data write. frame_done is counted over the whole run, which catches a missing pulse, a doubled pulse and a pulse that should not occur.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int REG_W = 32;
  localparam int PNL_W = 16;

  typedef enum logic [3:0] {
    A_SYSCFG  = 4'd0,
    A_STATUS  = 4'd1,
    A_CTRL    = 4'd2,
    A_PIXCNT  = 4'd3,
    A_CMD     = 4'd4,
    A_PARAM   = 4'd5,
    A_DATA    = 4'd6,
    A_RDDATA  = 4'd7,
    A_RDSTAT  = 4'd8,
    A_CFGA    = 4'd9,
    A_CFGB    = 4'd10
  } reg_addr_e;

  localparam logic [REG_W-1:0] CFG_RST   = 32'h0031_0000;
  localparam logic [REG_W-1:0] CFG_MASK  = 32'h003F_1FFF;
  localparam logic [REG_W-1:0] CFG_BLOCK = 32'h0000_000C;
  localparam logic [4:0]       IDLE_MASK = 5'h19;
  localparam logic [3:0]       CTRL_RST  = 4'h2;

  typedef enum logic [1:0] {S_IDLE, S_STB, S_REC} seq_state_e;
endpackage

// File: rtl/pfb_regs.sv
module pfb_regs
  import pfb_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic [3:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             disp_mode,
  input  logic             rx_load,
  input  logic [PNL_W-1:0] rx_data,
  output logic [REG_W-1:0] rdata,
  output logic             busy,
  output logic             frame_done,
  output logic             go,
  output logic             go_rd,
  output logic             go_dc,
  output logic             go_two,
  output logic [1:0]       go_cs,
  output logic [REG_W-1:0] go_data
);
  localparam logic [PIX_W-1:0] PIX_ONE = PIX_W'(1);

  logic [4:0]       idle_q, idle_d;
  logic [3:0]       ctrl_q, ctrl_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic [REG_W-1:0] cfga_q, cfga_d, cfgb_q, cfgb_d;
  logic             busy_q, busy_d, fd_q, fd_d;
  logic [PNL_W-1:0] rx_q, rx_d;
  logic             wr_acc, start_ok;
  logic [1:0]       sel;

  assign wr_acc = acc && wr;
  assign sel    = ctrl_q[3:2];
  assign start_ok = wdata[4] && wdata[0] && !wdata[1] && !busy_q && disp_mode &&
                    ((cfga_q & cfgb_q & CFG_BLOCK) == '0);

  // next-state
  always_comb begin
    idle_d = idle_q;
    ctrl_d = ctrl_q;
    pix_d  = pix_q;
    cfga_d = cfga_q;
    cfgb_d = cfgb_q;
    busy_d = busy_q;
    fd_d   = 1'b0;
    rx_d   = rx_load ? rx_data : rx_q;
    if (wr_acc) begin
      case (addr)
        A_SYSCFG: begin
          if (wdata[1]) begin
            ctrl_d = CTRL_RST;
            pix_d  = '0;
            cfga_d = CFG_RST;
            cfgb_d = CFG_RST;
            busy_d = 1'b0;
          end
          idle_d = wdata[4:0] & IDLE_MASK;
        end
        A_CTRL: begin
          ctrl_d = wdata[3:0];
          if (start_ok) busy_d = 1'b1;
        end
        A_PIXCNT: pix_d = wdata[PIX_W-1:0];
        A_DATA, A_RDDATA, A_RDSTAT: begin
          pix_d = pix_q - PIX_ONE;
          if (busy_q && pix_q == PIX_ONE) begin
            busy_d = 1'b0;
            fd_d   = 1'b1;
          end
        end
        A_CFGA: cfga_d = wdata & CFG_MASK;
        A_CFGB: cfgb_d = wdata & CFG_MASK;
        default: ;
      endcase
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      ctrl_q <= CTRL_RST;
      pix_q  <= '0;
      cfga_q <= CFG_RST;
      cfgb_q <= CFG_RST;
      busy_q <= 1'b0;
      fd_q   <= 1'b0;
      rx_q   <= '0;
    end else begin
      idle_q <= idle_d;
      ctrl_q <= ctrl_d;
      pix_q  <= pix_d;
      cfga_q <= cfga_d;
      cfgb_q <= cfgb_d;
      busy_q <= busy_d;
      fd_q   <= fd_d;
      rx_q   <= rx_d;
    end
  end

  // read mux
  always_comb begin
    case (addr)
      A_SYSCFG:           rdata = {27'd0, idle_q};
      A_STATUS:           rdata = {23'd0, busy_q, 7'd0, 1'b1};
      A_CTRL:             rdata = {28'd0, ctrl_q};
      A_PIXCNT:           rdata = REG_W'(pix_q);
      A_RDDATA, A_RDSTAT: rdata = {16'd0, rx_q};
      A_CFGA:             rdata = cfga_q;
      A_CFGB:             rdata = cfgb_q;
      default:            rdata = '0;
    endcase
  end

  // panel operation decode
  always_comb begin
    go      = 1'b0;
    go_rd   = 1'b0;
    go_dc   = 1'b1;
    go_two  = 1'b0;
    go_cs   = sel;
    go_data = wdata;
    if (wr_acc) begin
      case (addr)
        A_CMD:   begin go = (sel != 2'b00); go_dc = 1'b0; end
        A_PARAM: go = (sel != 2'b00);
        A_DATA:  begin go = (sel != 2'b00); go_two = 1'b1; end
        A_RDDATA, A_RDSTAT: begin
          go    = (sel != 2'b00);
          go_rd = 1'b1;
          go_dc = (addr == A_RDDATA);
          go_cs = sel[0] ? 2'b01 : 2'b10;
        end
        default: ;
      endcase
    end
  end

  assign busy       = busy_q;
  assign frame_done = fd_q;
endmodule

// File: rtl/pfb_seq.sv
module pfb_seq
  import pfb_pkg::*;
#(
  parameter int STB_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_rd,
  input  logic             go_dc,
  input  logic             go_two,
  input  logic [1:0]       go_cs,
  input  logic [REG_W-1:0] go_data,
  input  logic [PNL_W-1:0] pnl_din,
  output logic             idle,
  output logic [1:0]       pnl_cs_n,
  output logic             pnl_wr_n,
  output logic             pnl_rd_n,
  output logic             pnl_dc,
  output logic [PNL_W-1:0] pnl_dout,
  output logic             pnl_oe,
  output logic             rx_load,
  output logic [PNL_W-1:0] rx_data
);
  localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(STB_CYC - 1);

  seq_state_e       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             rd_q, rd_d, dc_q, dc_d, two_q, two_d;
  logic [1:0]       cs_q, cs_d;
  logic [REG_W-1:0] dat_q, dat_d;

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rd_d  = rd_q;
    dc_d  = dc_q;
    two_d = two_q;
    cs_d  = cs_q;
    dat_d = dat_q;
    case (st_q)
      S_IDLE: if (go) begin
        st_d  = S_STB;
        cnt_d = CNT_TOP;
        rd_d  = go_rd;
        dc_d  = go_dc;
        two_d = go_two;
        cs_d  = go_cs;
        dat_d = go_data;
      end
      S_STB: begin
        if (cnt_q == '0) st_d = S_REC;
        else             cnt_d = cnt_q - CW'(1);
      end
      S_REC: begin
        if (two_q) begin
          st_d  = S_STB;
          cnt_d = CNT_TOP;
          two_d = 1'b0;
          dat_d = dat_q >> PNL_W;
        end else begin
          st_d = S_IDLE;
          cs_d = 2'b00;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      rd_q  <= 1'b0;
      dc_q  <= 1'b1;
      two_q <= 1'b0;
      cs_q  <= 2'b00;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      dc_q  <= dc_d;
      two_q <= two_d;
      cs_q  <= cs_d;
      dat_q <= dat_d;
    end
  end

  assign idle     = (st_q == S_IDLE);
  assign pnl_cs_n = idle ? 2'b11 : ~cs_q;
  assign pnl_wr_n = !(st_q == S_STB && !rd_q);
  assign pnl_rd_n = !(st_q == S_STB && rd_q);
  assign pnl_dc   = dc_q;
  assign pnl_dout = dat_q[PNL_W-1:0];
  assign pnl_oe   = !idle && !rd_q;
  assign rx_load  = (st_q == S_STB) && rd_q && (cnt_q == '0);
  assign rx_data  = pnl_din;
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int STB_CYC = 2,
  parameter int PIX_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_wr,
  input  logic [3:0]           host_addr,
  input  logic [REG_W-1:0]     host_wdata,
  output logic [REG_W-1:0]     host_rdata,
  output logic                 host_ready,
  input  logic                 disp_mode,
  output logic [1:0]           pnl_cs_n,
  output logic                 pnl_wr_n,
  output logic                 pnl_rd_n,
  output logic                 pnl_dc,
  output logic [PNL_W-1:0]     pnl_dout,
  output logic                 pnl_oe,
  input  logic [PNL_W-1:0]     pnl_din,
  output logic                 frame_done
);
  logic [1:0]       rst_sync_q;
  logic             rst_int;
  logic             busy, go, go_rd, go_dc, go_two, rx_load, seq_idle;
  logic [1:0]       go_cs;
  logic [REG_W-1:0] go_data;
  logic [PNL_W-1:0] rx_data;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  assign host_ready = seq_idle;

  pfb_regs #(.PIX_W(PIX_W)) u_regs (
    .clk(clk), .rst_n(rst_int),
    .acc(host_req && seq_idle), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .disp_mode(disp_mode), .rx_load(rx_load), .rx_data(rx_data),
    .rdata(host_rdata), .busy(busy), .frame_done(frame_done),
    .go(go), .go_rd(go_rd), .go_dc(go_dc), .go_two(go_two),
    .go_cs(go_cs), .go_data(go_data)
  );

  pfb_seq #(.STB_CYC(STB_CYC)) u_seq (
    .clk(clk), .rst_n(rst_int),
    .go(go), .go_rd(go_rd), .go_dc(go_dc), .go_two(go_two),
    .go_cs(go_cs), .go_data(go_data), .pnl_din(pnl_din),
    .idle(seq_idle), .pnl_cs_n(pnl_cs_n), .pnl_wr_n(pnl_wr_n),
    .pnl_rd_n(pnl_rd_n), .pnl_dc(pnl_dc), .pnl_dout(pnl_dout),
    .pnl_oe(pnl_oe), .rx_load(rx_load), .rx_data(rx_data)
  );
endmodule

// File: rtl/pfb_ctrl_chk.sv
module pfb_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_ready,
  input logic       pnl_wr_n,
  input logic       pnl_rd_n,
  input logic [1:0] pnl_cs_n,
  input logic       frame_done,
  input logic       busy
);
  // R12
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pnl_wr_n && !pnl_rd_n));

  // R10
  strobe_stalls_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_wr_n || !pnl_rd_n) |-> !host_ready);

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (pnl_cs_n == 2'b11 && pnl_wr_n && pnl_rd_n));

  // R5
  strobe_has_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_wr_n |-> (pnl_cs_n != 2'b11));

  // R12
  read_single_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_rd_n |-> ($countones(~pnl_cs_n) == 1));

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && $past(busy)));

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind pfb_ctrl pfb_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_int), .host_ready(host_ready),
  .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n), .pnl_cs_n(pnl_cs_n),
  .frame_done(frame_done), .busy(busy)
);

// File: tb/sim_pfb_ctrl.sv
module sim_pfb_ctrl;
  localparam int STB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0, disp_mode = 1'b0;
  logic [3:0]  host_addr = 4'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        host_ready, pnl_wr_n, pnl_rd_n, pnl_dc, pnl_oe, frame_done;
  logic [1:0]  pnl_cs_n;
  logic [15:0] pnl_dout, pnl_din;

  int checks = 0, errors = 0;
  int nlog = 0, fd_count = 0, wcnt = 0, dual = 0;
  logic [15:0] lg_dat [0:63];
  logic        lg_dc  [0:63];
  logic        lg_rd  [0:63];
  logic [1:0]  lg_cs  [0:63];
  int          lg_w   [0:63];
  logic        prev_low = 1'b0;
  logic        prev_rd = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  assign pnl_din = !pnl_cs_n[0] ? 16'h1234 : (!pnl_cs_n[1] ? 16'hBEEF : 16'h0000);

  pfb_ctrl #(.STB_CYC(STB)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .disp_mode(disp_mode), .pnl_cs_n(pnl_cs_n),
    .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n), .pnl_dc(pnl_dc),
    .pnl_dout(pnl_dout), .pnl_oe(pnl_oe), .pnl_din(pnl_din),
    .frame_done(frame_done)
  );

  // panel model: log each strobe when it rises
  always @(negedge clk) begin
    if (frame_done) fd_count++;
    if (!pnl_wr_n && !pnl_rd_n) dual++;
    if (!pnl_wr_n || !pnl_rd_n) begin
      wcnt++;
      prev_low = 1'b1;
      prev_rd  = !pnl_rd_n;
    end else if (prev_low) begin
      if (nlog < 64) begin
        lg_dat[nlog] = prev_rd ? 16'h0 : pnl_dout;
        lg_dc[nlog]  = pnl_dc;
        lg_rd[nlog]  = prev_rd;
        lg_cs[nlog]  = pnl_cs_n;
        lg_w[nlog]   = wcnt;
      end
      nlog++;
      wcnt = 0;
      prev_low = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_addr = a;
    #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic idle_wait();
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'd0, host_ready}, 32'd1);
    chk("R1 cs_n", {30'd0, pnl_cs_n}, 32'd3);
    chk("R1 strobes", {30'd0, pnl_wr_n, pnl_rd_n}, 32'd3);
    rd_chk("R1 ctrl", 4'd2, 32'd2);
    rd_chk("R1 cfgA", 4'd9, 32'h0031_0000);
    rd_chk("R1 cfgB", 4'd10, 32'h0031_0000);
    rd_chk("R1 status", 4'd1, 32'h1);
    rd_chk("R1 pixcnt", 4'd3, 32'h0);
  endtask

  task automatic t_masks();
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl mask", 4'd2, 32'hF);
    rd_chk("R3 bypass refuses start", 4'd1, 32'h1);
    wr(4'd9, 32'hFFFF_FFFF);
    rd_chk("R2 cfgA mask", 4'd9, 32'h003F_1FFF);
    wr(4'd9, 32'h0031_0000);
    wr(4'd0, 32'hFFFF_FFFD);
    rd_chk("R2 sysconfig mask", 4'd0, 32'h19);
  endtask

  task automatic t_cmd_param();
    int base;
    wr(4'd2, 32'h5);
    base = nlog;
    wr(4'd4, 32'hABCD_1234);
    chk("R10 ready low during strobe", {31'd0, host_ready}, 32'd0);
    idle_wait();
    chk("R5 one strobe", nlog - base, 1);
    chk("R5 cmd data", {16'd0, lg_dat[base]}, 32'h1234);
    chk("R5 cmd level", {31'd0, lg_dc[base]}, 32'd0);
    chk("R5 cmd cs panel0", {30'd0, lg_cs[base]}, 32'd2);
    chk("R10 strobe width", lg_w[base], STB);
    wr(4'd2, 32'hD);
    base = nlog;
    wr(4'd5, 32'h0000_5678);
    idle_wait();
    chk("R6 param data", {16'd0, lg_dat[base]}, 32'h5678);
    chk("R6 param level", {31'd0, lg_dc[base]}, 32'd1);
    chk("R5 both panels", {30'd0, lg_cs[base]}, 32'd0);
  endtask

  task automatic t_data();
    int base, lowc;
    wr(4'd2, 32'h5);
    base = nlog;
    lowc = 0;
    wr(4'd6, 32'h9999_1111);
    while (!host_ready) begin lowc++; @(negedge clk); end
    idle_wait();
    chk("R10 ready low cycles", lowc, 2 * (STB + 1));
    chk("R7 two strobes", nlog - base, 2);
    chk("R7 low half first", {16'd0, lg_dat[base]}, 32'h1111);
    chk("R7 high half second", {16'd0, lg_dat[base+1]}, 32'h9999);
    chk("R7 data level", {30'd0, lg_dc[base], lg_dc[base+1]}, 32'd3);
  endtask

  task automatic t_nosel();
    int base;
    wr(4'd2, 32'h1);
    base = nlog;
    wr(4'd4, 32'h0000_00AA);
    chk("R10 no panel ready", {31'd0, host_ready}, 32'd1);
    idle_wait();
    chk("R10 no panel no strobe", nlog - base, 0);
  endtask

  task automatic t_read();
    int base;
    wr(4'd2, 32'hD);
    base = nlog;
    wr(4'd7, 32'h0);
    idle_wait();
    chk("R9 read strobe", {31'd0, lg_rd[base]}, 32'd1);
    chk("R9 panel0 priority", {30'd0, lg_cs[base]}, 32'd2);
    chk("R9 data level", {31'd0, lg_dc[base]}, 32'd1);
    rd_chk("R9 rx panel0", 4'd7, 32'h1234);
    wr(4'd2, 32'h9);
    base = nlog;
    wr(4'd8, 32'h0);
    idle_wait();
    chk("R9 panel1 cs", {30'd0, lg_cs[base]}, 32'd1);
    chk("R9 status level", {31'd0, lg_dc[base]}, 32'd0);
    rd_chk("R9 rx panel1", 4'd8, 32'hBEEF);
  endtask

  task automatic t_transfer();
    int fd0;
    wr(4'd3, 32'd2);
    disp_mode = 1'b0;
    wr(4'd2, 32'h15);
    rd_chk("R3 mode low refuses", 4'd1, 32'h1);
    disp_mode = 1'b1;
    wr(4'd9, 32'h0000_000C);
    wr(4'd10, 32'h0031_0004);
    wr(4'd2, 32'h15);
    rd_chk("R4 cfg conflict refuses", 4'd1, 32'h1);
    wr(4'd10, 32'h0031_0000);
    wr(4'd2, 32'h15);
    rd_chk("R3 start busy", 4'd1, 32'h101);
    fd0 = fd_count;
    wr(4'd6, 32'h0002_0001);
    rd_chk("R8 count down", 4'd3, 32'd1);
    wr(4'd4, 32'h0);
    rd_chk("R8 cmd keeps count", 4'd3, 32'd1);
    rd_chk("R8 still busy", 4'd1, 32'h101);
    wr(4'd6, 32'h0004_0003);
    idle_wait();
    rd_chk("R8 busy cleared", 4'd1, 32'h1);
    rd_chk("R8 count zero", 4'd3, 32'd0);
    chk("R8 one frame_done", fd_count - fd0, 1);
  endtask

  task automatic t_softreset();
    int fd0;
    wr(4'd3, 32'd5);
    wr(4'd2, 32'h15);
    rd_chk("R3 restart busy", 4'd1, 32'h101);
    fd0 = fd_count;
    wr(4'd9, 32'h0000_0ABC);
    wr(4'd0, 32'h0000_001B);
    rd_chk("R11 ctrl reset", 4'd2, 32'd2);
    rd_chk("R11 cfgA reset", 4'd9, 32'h0031_0000);
    rd_chk("R11 busy cleared", 4'd1, 32'h1);
    rd_chk("R11 pixcnt reset", 4'd3, 32'd0);
    rd_chk("R11 idle field", 4'd0, 32'h19);
    chk("R11 no frame_done", fd_count - fd0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_masks();
    t_cmd_param();
    t_data();
    t_nosel();
    t_read();
    t_transfer();
    t_softreset();
    chk("R12 no dual strobe", dual, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule